// File: doc/BRIEF.md
# NAND Flash Device Responder

This block is the device side of a small raw NAND flash with an 8-bit bus. A host drives chip enable, a command-latch and an address-latch qualifier, and one-cycle write and read strobes. The block decodes the command bytes and two-cycle command pairs, gathers address bytes, keeps a page register between the bus and the internal array, and answers page read, page program, block erase, identification and status requests. It is meant to sit in a system-level bench or an emulation build, in place of a real flash part, behind a flash controller.

Storage is a reduced array whose geometry is set by parameters: blocks of a power-of-two number of pages, each page a main region followed by a spare region. After a read confirm, a program confirm or an erase confirm, a counter holds the ready/busy output low for a set number of clocks. The reset command holds it low for its own shorter count. While busy, the block accepts only the status command and the reset command.

Top module: `nand_flash_responder`

## Requirements
- R1: After rst_n is released, rb is 1 and the status byte reads 0x40.
- R2: Command 0x90 followed by one address byte returns, on successive reads, 0xEC, DEVICE_CODE, 0x00, 0x95, 0x40, then 0xFF for any further reads.
- R3: Command 0x00, four address bytes (column low, column high, row low, row high) and command 0x30 copy the addressed page into the page register. rb is then 0 for exactly BUSY_CYCLES clocks, starting the cycle after the 0x30 write, and reads return page bytes from the given column.
- R4: Command 0x80, four address bytes, data bytes and command 0x10 store old AND new into each page byte. A byte not written keeps its old value, because the page register is preset to 0xFF on 0x80.
- R5: Command 0x60, two row bytes (low, high) and command 0xD0 set every byte of the addressed block to 0xFF and leave other blocks unchanged.
- R6: Each data read or write moves the column pointer up by one, until it reaches the page end (main plus spare bytes). Reads at or past the page end return 0xFF, and writes there are dropped.
- R7: In data output, command 0x05, two column bytes and command 0xE0 move the read pointer to the new column within the loaded page.
- R8: During a program, command 0x85 and two column bytes move the write pointer without changing the target row or the bytes already loaded.
- R9: After command 0x70, reads return a status byte with bit 6 equal to ready and bit 0 set when the last program tried to turn a 0 bit into 1. An erase or a clean program clears bit 0.
- R10: Command 0xFF returns to idle, clears the fail bit and the column pointer, and holds rb at 0 for exactly RESET_CYCLES clocks.
- R11: While rb is 0, every command other than 0x70 and 0xFF has no effect, and address and data writes are dropped.
- R12: The row address is taken modulo the total page count, and its upper bits (row / PAGES_PER_BLOCK) select the block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Marks a write as a command byte |
| ale | input | 1 | Marks a write as an address byte |
| wr_stb | input | 1 | One-cycle write strobe |
| rd_stb | input | 1 | One-cycle read strobe; consumes the byte on dout |
| din | input | 8 | Host-to-device byte |
| dout | output | 8 | Device-to-host byte for the current read position |
| rb | output | 1 | Ready (1) / busy (0) |

## Verification
The bench builds the block with 16 main and 4 spare bytes per page, 4 pages per block, 2 blocks, a busy count of 5 and a reset count of 3. At these sizes a single read walks past the spare region into the 0xFF tail. A row of 6 erases the block that holds row 5, which shows the block being picked from the upper row bits. Every busy window is short enough that the commands sent inside it (an ignored 0x90, and a status poll) land while rb is low.

// File: rtl/nand_resp_pkg.sv
// Shared command codes, the decoder's mode type and the ID byte table for
// the NAND device responder. Assumes an 8-bit bus.
package nand_resp_pkg;

    localparam logic [7:0] OP_READ_SETUP  = 8'h00;
    localparam logic [7:0] OP_READ_GO     = 8'h30;
    localparam logic [7:0] OP_PROG_SETUP  = 8'h80;
    localparam logic [7:0] OP_PROG_GO     = 8'h10;
    localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
    localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
    localparam logic [7:0] OP_COL_OUT     = 8'h05;
    localparam logic [7:0] OP_COL_OUT_GO  = 8'hE0;
    localparam logic [7:0] OP_COL_IN      = 8'h85;
    localparam logic [7:0] OP_STATUS      = 8'h70;
    localparam logic [7:0] OP_IDENT       = 8'h90;
    localparam logic [7:0] OP_RESET       = 8'hFF;

    typedef enum logic [2:0] {
        MD_IDLE,
        MD_RD_ADDR,
        MD_DATA_OUT,
        MD_RCOL,
        MD_PROG,
        MD_ERASE,
        MD_ID,
        MD_STATUS
    } mode_t;

    // Identification byte for a given position in the five-byte sequence.
    function automatic logic [7:0] id_byte(logic [2:0] idx, logic [7:0] dev);
        case (idx)
            3'd0:    return 8'hEC;
            3'd1:    return dev;
            3'd2:    return 8'h00;
            3'd3:    return 8'h95;
            3'd4:    return 8'h40;
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/nand_busy_timer.sv
// Ready/busy down-counter. Loading a non-zero value holds busy high for
// exactly that many clocks, starting the cycle after the load.
// Assumes load values fit in CNT_W bits.
module nand_busy_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy
);

    logic [CNT_W-1:0] cnt_q;

    // Count down to zero; a new load takes precedence.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/nand_addr_latch.sv
// Collects address bytes in arrival order. A clear (any accepted command)
// restarts the sequence but keeps the stored bytes, so a column-only
// sequence leaves the earlier row bytes in place. Extra bytes are dropped.
module nand_addr_latch #(
    parameter int NUM_BYTES = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear,
    input  logic                          push,
    input  logic [7:0]                    din,
    output logic [NUM_BYTES-1:0][7:0]     bytes_o,
    output logic [$clog2(NUM_BYTES+1)-1:0] count_o
);

    localparam int CNT_W = $clog2(NUM_BYTES + 1);
    localparam int IDX_W = $clog2(NUM_BYTES);

    logic [NUM_BYTES-1:0][7:0] bytes_q;
    logic [CNT_W-1:0]          count_q;

    // Store each pushed byte at the next slot and advance the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bytes_q <= '0;
            count_q <= '0;
        end else if (clear) begin
            count_q <= '0;
        end else if (push && (count_q < CNT_W'(NUM_BYTES))) begin
            bytes_q[count_q[IDX_W-1:0]] <= din;
            count_q <= count_q + 1'b1;
        end
    end

    assign bytes_o = bytes_q;
    assign count_o = count_q;

endmodule

// File: rtl/nand_flash_responder.sv
// Device-side NAND flash responder. It decodes command and address cycles,
// holds a page register, and serves page read, program (AND into the
// array), block erase, ID and status. Assumes PAGES_PER_BLOCK and BLOCKS are
// powers of two with BLOCKS >= 2, and total storage of at most a few thousand
// bytes. The reset state of the array is fully erased (0xFF).
module nand_flash_responder
    import nand_resp_pkg::*;
#(
    parameter int         PAGE_MAIN       = 16,
    parameter int         PAGE_SPARE      = 4,
    parameter int         PAGES_PER_BLOCK = 4,
    parameter int         BLOCKS          = 2,
    parameter int         BUSY_CYCLES     = 8,
    parameter int         RESET_CYCLES    = 4,
    parameter logic [7:0] DEVICE_CODE     = 8'hF1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       cle,
    input  logic       ale,
    input  logic       wr_stb,
    input  logic       rd_stb,
    input  logic [7:0] din,
    output logic [7:0] dout,
    output logic       rb
);

    localparam int PAGE_BYTES  = PAGE_MAIN + PAGE_SPARE;
    localparam int TOTAL_PAGES = PAGES_PER_BLOCK * BLOCKS;
    localparam int BLOCK_BYTES = PAGES_PER_BLOCK * PAGE_BYTES;
    localparam int TOTAL_BYTES = TOTAL_PAGES * PAGE_BYTES;
    localparam int ROW_W       = $clog2(TOTAL_PAGES);
    localparam int PG_W        = $clog2(PAGES_PER_BLOCK);
    localparam int BLK_W       = ROW_W - PG_W;
    localparam int MEM_AW      = $clog2(TOTAL_BYTES);
    localparam int PGI_W       = $clog2(PAGE_BYTES);
    localparam int MAX_WAIT    = (BUSY_CYCLES > RESET_CYCLES) ? BUSY_CYCLES : RESET_CYCLES;
    localparam int BUSY_W      = $clog2(MAX_WAIT + 1);
    localparam logic [15:0] PAGE_END = 16'(PAGE_BYTES);

    // Bus qualifiers
    logic cmd_wr, addr_wr, data_wr, data_rd, cmd_ok, busy;
    logic start_op, start_rst;

    // Decoder and storage state
    mode_t       mode_q;
    logic [15:0] col_q;
    logic        fail_q;
    logic [2:0]  id_q;
    logic [7:0]  mem [TOTAL_BYTES];
    logic [7:0]  pg  [PAGE_BYTES];

    // Address latch outputs and decoded locations
    logic [3:0][7:0]  abytes;
    logic [2:0]       acnt;
    logic [15:0]      addr_lo16, addr_hi16;
    logic [ROW_W-1:0] row_sel, erase_row;
    logic [BLK_W-1:0] erase_blk;
    logic [MEM_AW-1:0] pg_base, blk_base;
    logic             prog_fail;

    // Classify the bus cycle.
    always_comb begin
        cmd_wr  = !ce_n && wr_stb && cle && !ale;
        addr_wr = !ce_n && wr_stb && ale && !cle;
        data_wr = !ce_n && wr_stb && !cle && !ale;
        data_rd = !ce_n && rd_stb;
        cmd_ok  = cmd_wr && (!busy || din == OP_STATUS || din == OP_RESET);
    end

    nand_addr_latch #(.NUM_BYTES(4)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cmd_ok),
        .push    (addr_wr && !busy),
        .din     (din),
        .bytes_o (abytes),
        .count_o (acnt)
    );

    // Turn latched bytes into the page and block the array operation uses.
    always_comb begin
        addr_lo16 = {abytes[1], abytes[0]};
        addr_hi16 = {abytes[3], abytes[2]};
        row_sel   = ROW_W'(addr_hi16);
        erase_row = ROW_W'(addr_lo16);
        erase_blk = erase_row[ROW_W-1:PG_W];
        pg_base   = MEM_AW'(row_sel) * MEM_AW'(PAGE_BYTES);
        blk_base  = MEM_AW'(erase_blk) * MEM_AW'(BLOCK_BYTES);
    end

    // A program fails if any loaded 1 bit lands on an array 0 bit.
    always_comb begin
        prog_fail = 1'b0;
        for (int j = 0; j < PAGE_BYTES; j++)
            prog_fail = prog_fail | (|(pg[j] & ~mem[pg_base + MEM_AW'(j)]));
    end

    // Decide which confirm starts a busy window.
    always_comb begin
        start_rst = cmd_ok && (din == OP_RESET);
        start_op  = cmd_ok && ((din == OP_READ_GO  && mode_q == MD_RD_ADDR) ||
                               (din == OP_PROG_GO  && mode_q == MD_PROG)    ||
                               (din == OP_ERASE_GO && mode_q == MD_ERASE));
    end

    nand_busy_timer #(.CNT_W(BUSY_W)) u_busy (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_op || start_rst),
        .load_val (start_rst ? BUSY_W'(RESET_CYCLES) : BUSY_W'(BUSY_CYCLES)),
        .busy     (busy)
    );

    assign rb = !busy;

    // Command decode, pointer movement, page register and array updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MD_IDLE;
            col_q  <= '0;
            fail_q <= 1'b0;
            id_q   <= '0;
            for (int j = 0; j < TOTAL_BYTES; j++) mem[j] <= 8'hFF;
            for (int j = 0; j < PAGE_BYTES; j++)  pg[j]  <= 8'hFF;
        end else if (cmd_ok) begin
            case (din)
                OP_READ_SETUP:  mode_q <= MD_RD_ADDR;
                OP_READ_GO: begin
                    if (mode_q == MD_RD_ADDR) begin
                        for (int j = 0; j < PAGE_BYTES; j++)
                            pg[j] <= mem[pg_base + MEM_AW'(j)];
                        mode_q <= MD_DATA_OUT;
                    end else
                        mode_q <= MD_IDLE;
                end
                OP_PROG_SETUP: begin
                    for (int j = 0; j < PAGE_BYTES; j++) pg[j] <= 8'hFF;
                    mode_q <= MD_PROG;
                end
                OP_COL_IN: if (mode_q != MD_PROG) mode_q <= MD_IDLE;
                OP_PROG_GO: begin
                    if (mode_q == MD_PROG) begin
                        for (int j = 0; j < PAGE_BYTES; j++)
                            mem[pg_base + MEM_AW'(j)] <= mem[pg_base + MEM_AW'(j)] & pg[j];
                        fail_q <= prog_fail;
                    end
                    mode_q <= MD_IDLE;
                end
                OP_ERASE_SETUP: mode_q <= MD_ERASE;
                OP_ERASE_GO: begin
                    if (mode_q == MD_ERASE) begin
                        for (int j = 0; j < BLOCK_BYTES; j++)
                            mem[blk_base + MEM_AW'(j)] <= 8'hFF;
                        fail_q <= 1'b0;
                    end
                    mode_q <= MD_IDLE;
                end
                OP_COL_OUT:    mode_q <= (mode_q == MD_DATA_OUT) ? MD_RCOL : MD_IDLE;
                OP_COL_OUT_GO: mode_q <= (mode_q == MD_RCOL) ? MD_DATA_OUT : MD_IDLE;
                OP_IDENT: begin
                    mode_q <= MD_ID;
                    id_q   <= '0;
                end
                OP_STATUS:     mode_q <= MD_STATUS;
                OP_RESET: begin
                    mode_q <= MD_IDLE;
                    fail_q <= 1'b0;
                    col_q  <= '0;
                end
                default:       mode_q <= MD_IDLE;
            endcase
        end else if (addr_wr && !busy) begin
            if (acnt < 3'd2 && (mode_q == MD_RD_ADDR || mode_q == MD_PROG || mode_q == MD_RCOL)) begin
                if (acnt[0]) col_q[15:8] <= din;
                else         col_q[7:0]  <= din;
            end
            if (mode_q == MD_ID) id_q <= '0;
        end else if (data_wr && !busy && mode_q == MD_PROG) begin
            if (col_q < PAGE_END) begin
                pg[col_q[PGI_W-1:0]] <= din;
                col_q <= col_q + 16'd1;
            end
        end else if (data_rd) begin
            if (mode_q == MD_DATA_OUT && !busy && col_q < PAGE_END)
                col_q <= col_q + 16'd1;
            if (mode_q == MD_ID && id_q < 3'd5)
                id_q <= id_q + 3'd1;
        end
    end

    // Select the byte presented to the host.
    always_comb begin
        case (mode_q)
            MD_STATUS: dout = {1'b0, rb, 5'b0, fail_q};
            MD_ID:     dout = id_byte(id_q, DEVICE_CODE);
            MD_DATA_OUT, MD_RCOL:
                dout = busy ? 8'h00 :
                       (col_q < PAGE_END) ? pg[col_q[PGI_W-1:0]] : 8'hFF;
            default:   dout = 8'hFF;
        endcase
    end

endmodule

// File: rtl/nand_flash_responder_chk.sv
// Protocol checker for the NAND responder, bound to every instance.
module nand_flash_responder_chk
    import nand_resp_pkg::*;
#(
    parameter int PAGE_BYTES = 20
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_wr,
    input logic        addr_wr,
    input logic        data_rd,
    input logic [7:0]  din,
    input logic [7:0]  dout,
    input logic        rb,
    input mode_t       mode,
    input logic [15:0] col_ptr
);

    // R3: an accepted read confirm drops ready on the next cycle.
    p_read_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && din == OP_READ_GO && rb && mode == MD_RD_ADDR) |=> !rb);

    // R10: the reset command always drops ready on the next cycle.
    p_reset_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && din == OP_RESET) |=> !rb);

    // R11: ready only falls right after a command write.
    p_busy_origin_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rb) |-> $past(cmd_wr));

    // R11: an ID command during busy leaves the decoder mode unchanged.
    p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !rb && din == OP_IDENT) |=> (mode == $past(mode)));

    // R6: a read inside the page advances the column by one.
    p_col_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && rb && mode == MD_DATA_OUT && col_ptr < 16'(PAGE_BYTES))
        |=> (col_ptr == $past(col_ptr) + 16'd1));

    // R2: the address byte after the ID command restarts at the maker code.
    p_id_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_wr && rb && mode == MD_ID) |=> (dout == 8'hEC));

endmodule

bind nand_flash_responder nand_flash_responder_chk #(.PAGE_BYTES(PAGE_BYTES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_wr  (cmd_wr),
    .addr_wr (addr_wr),
    .data_rd (data_rd),
    .din     (din),
    .dout    (dout),
    .rb      (rb),
    .mode    (mode_q),
    .col_ptr (col_q)
);

// File: tb/nand_flash_responder_test.sv
// Bench: behavioural reference model compared with rb every clock and with
// dout on every read.
module nand_flash_responder_test;

    localparam int MAIN = 16, SPARE = 4, PPB = 4, NBLK = 2;
    localparam int BUSYC = 5, RSTC = 3;
    localparam logic [7:0] DEV = 8'hF1;
    localparam int PB = MAIN + SPARE;
    localparam int TP = PPB * NBLK;
    localparam int K_IDLE = 0, K_RDA = 1, K_DOUT = 2, K_RCOL = 3,
                   K_PROG = 4, K_ERA = 5, K_ID = 6, K_STAT = 7;

    logic clk = 1'b0;
    logic rst_n, ce_n, cle, ale, wr_stb, rd_stb;
    logic [7:0] din, dout;
    logic rb;

    always #4 clk = ~clk;

    nand_flash_responder #(
        .PAGE_MAIN(MAIN), .PAGE_SPARE(SPARE), .PAGES_PER_BLOCK(PPB),
        .BLOCKS(NBLK), .BUSY_CYCLES(BUSYC), .RESET_CYCLES(RSTC),
        .DEVICE_CODE(DEV)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .din(din), .dout(dout), .rb(rb)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    // reference model state
    logic [7:0] mm [int];
    logic [7:0] mpg [PB];
    logic [7:0] ab [4];
    int mb = 0, pend = 0, mmode = K_IDLE, mcol = 0, mid = 0, an = 0;
    logic mfail = 0;

    function automatic logic [7:0] mget(int a);
        return mm.exists(a) ? mm[a] : 8'hFF;
    endfunction

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // one clock: model busy count follows, then rb is compared
    task automatic tick();
        @(posedge clk);
        #1;
        if (mb > 0) mb--;
        if (pend > 0) begin mb = pend; pend = 0; end
        @(negedge clk);
        chk("R3/R10 rb", {7'b0, rb}, {7'b0, (mb == 0)});
    endtask

    task automatic idle_bus();
        wr_stb = 0; rd_stb = 0; cle = 0; ale = 0;
    endtask

    task automatic model_cmd(logic [7:0] c);
        int row, blk;
        if (mb > 0 && c != 8'h70 && c != 8'hFF) return;
        an = 0;
        case (c)
            8'h00: mmode = K_RDA;
            8'h30: begin
                if (mmode == K_RDA) begin
                    row = ({ab[3], ab[2]}) % TP;
                    for (int j = 0; j < PB; j++) mpg[j] = mget(row * PB + j);
                    pend = BUSYC; mmode = K_DOUT;
                end else mmode = K_IDLE;
            end
            8'h80: begin for (int j = 0; j < PB; j++) mpg[j] = 8'hFF; mmode = K_PROG; end
            8'h85: if (mmode != K_PROG) mmode = K_IDLE;
            8'h10: begin
                if (mmode == K_PROG) begin
                    row = ({ab[3], ab[2]}) % TP;
                    mfail = 0;
                    for (int j = 0; j < PB; j++) begin
                        logic [7:0] old;
                        old = mget(row * PB + j);
                        if ((mpg[j] & ~old) != 0) mfail = 1;
                        mm[row * PB + j] = old & mpg[j];
                    end
                    pend = BUSYC;
                end
                mmode = K_IDLE;
            end
            8'h60: mmode = K_ERA;
            8'hD0: begin
                if (mmode == K_ERA) begin
                    row = ({ab[1], ab[0]}) % TP;
                    blk = row / PPB;
                    for (int j = 0; j < PPB * PB; j++) mm[blk * PPB * PB + j] = 8'hFF;
                    mfail = 0; pend = BUSYC;
                end
                mmode = K_IDLE;
            end
            8'h05: mmode = (mmode == K_DOUT) ? K_RCOL : K_IDLE;
            8'hE0: mmode = (mmode == K_RCOL) ? K_DOUT : K_IDLE;
            8'h90: begin mmode = K_ID; mid = 0; end
            8'h70: mmode = K_STAT;
            8'hFF: begin mmode = K_IDLE; mfail = 0; mcol = 0; pend = RSTC; end
            default: mmode = K_IDLE;
        endcase
    endtask

    task automatic cmd(logic [7:0] c);
        ce_n = 0; cle = 1; ale = 0; wr_stb = 1; din = c;
        model_cmd(c);
        tick();
        idle_bus();
    endtask

    task automatic addr(logic [7:0] v);
        ce_n = 0; ale = 1; cle = 0; wr_stb = 1; din = v;
        if (mb == 0 && an < 4) begin
            ab[an] = v;
            if (an < 2 && (mmode == K_RDA || mmode == K_PROG || mmode == K_RCOL)) begin
                if (an == 0) mcol = (mcol & 'hFF00) | int'(v);
                else         mcol = (mcol & 'h00FF) | (int'(v) << 8);
            end
            an++;
        end
        if (mb == 0 && mmode == K_ID) mid = 0;
        tick();
        idle_bus();
    endtask

    task automatic wr(logic [7:0] v);
        ce_n = 0; wr_stb = 1; din = v;
        if (mb == 0 && mmode == K_PROG && mcol < PB) begin
            mpg[mcol] = v; mcol++;
        end
        tick();
        idle_bus();
    endtask

    task automatic rd(string req);
        logic [7:0] exp;
        ce_n = 0; rd_stb = 1;
        #1;
        case (mmode)
            K_STAT: exp = {1'b0, (mb == 0), 5'b0, mfail};
            K_ID: begin
                case (mid)
                    0: exp = 8'hEC; 1: exp = DEV; 2: exp = 8'h00;
                    3: exp = 8'h95; 4: exp = 8'h40; default: exp = 8'hFF;
                endcase
            end
            K_DOUT, K_RCOL: exp = (mcol < PB) ? mpg[mcol] : 8'hFF;
            default: exp = 8'hFF;
        endcase
        if (mb > 0 && (mmode == K_DOUT || mmode == K_RCOL)) begin
            checks++; fails++;
            $display("FAIL %s: data read while busy, got %02h expected ready", req, dout);
        end else
            chk(req, dout, exp);
        if (mmode == K_DOUT && mb == 0 && mcol < PB) mcol++;
        if (mmode == K_ID && mid < 5) mid++;
        tick();
        idle_bus();
    endtask

    task automatic wait_ready();
        while (mb > 0) tick();
    endtask

    task automatic addr4(logic [7:0] c0, logic [7:0] c1, logic [7:0] r0, logic [7:0] r1);
        addr(c0); addr(c1); addr(r0); addr(r1);
    endtask

    initial begin
        rst_n = 0; ce_n = 1; din = 0;
        idle_bus();
        repeat (3) tick();
        rst_n = 1;
        tick();

        // R1: reset state
        cmd(8'h70); rd("R1 status after reset");

        // R2: ID sequence and tail
        cmd(8'h90); addr(8'h00);
        for (int i = 0; i < 6; i++) rd("R2 id byte");

        // R4: program row 1 of block 0
        cmd(8'h80); addr4(8'd0, 8'd0, 8'd1, 8'd0);
        wr(8'h0F); wr(8'h3C);
        cmd(8'h10); wait_ready();
        cmd(8'h70); rd("R9 clean program status");

        // R4/R8: program row 5 at column 2, then move to spare with 0x85
        cmd(8'h80); addr4(8'd2, 8'd0, 8'd5, 8'd0);
        wr(8'hA5); wr(8'h5A); wr(8'hC3);
        cmd(8'h85); addr(8'd18); addr(8'd0);
        wr(8'h12); wr(8'h34); wr(8'h56);   // third write is past the page end (R6)
        cmd(8'h10); wait_ready();

        // R3/R11: read row 5; an ID command sent while busy is ignored
        cmd(8'h00); addr4(8'd0, 8'd0, 8'd5, 8'd0);
        cmd(8'h30);
        cmd(8'h90);
        wait_ready();
        for (int i = 0; i < PB + 2; i++) rd("R3/R6/R8/R11 page read");

        // R7: random data output to column 3
        cmd(8'h05); addr(8'd3); addr(8'd0); cmd(8'hE0);
        rd("R7 random out"); rd("R7 random out next");

        // R9/R4: program that tries to raise bits
        cmd(8'h80); addr4(8'd2, 8'd0, 8'd5, 8'd0);
        wr(8'hFF); wr(8'h0F);
        cmd(8'h10); wait_ready();
        cmd(8'h70); rd("R9 fail status");
        cmd(8'h00); addr4(8'd2, 8'd0, 8'd5, 8'd0); cmd(8'h30); wait_ready();
        rd("R4 and-merge"); rd("R4 and-merge"); rd("R4 untouched");

        // R5/R12: erase the block holding row 5 through row 6; poll status while busy
        cmd(8'h60); addr(8'd6); addr(8'd0); cmd(8'hD0);
        cmd(8'h70); rd("R9 status busy");
        wait_ready();
        rd("R5 status after erase");
        cmd(8'h00); addr4(8'd0, 8'd0, 8'd5, 8'd0); cmd(8'h30); wait_ready();
        for (int i = 0; i < 4; i++) rd("R5/R12 erased page");
        cmd(8'h00); addr4(8'd0, 8'd0, 8'd1, 8'd0); cmd(8'h30); wait_ready();
        rd("R5 other block kept"); rd("R5 other block kept");

        // R12: row beyond the array wraps (row 9 -> row 1)
        cmd(8'h00); addr4(8'd0, 8'd0, 8'd9, 8'd0); cmd(8'h30); wait_ready();
        rd("R12 row wrap");

        // R10: set fail, then reset command clears it
        cmd(8'h80); addr4(8'd0, 8'd0, 8'd1, 8'd0); wr(8'hFF);
        cmd(8'h10); wait_ready();
        cmd(8'h70); rd("R9 fail again");
        cmd(8'hFF); wait_ready();
        cmd(8'h70); rd("R10 status after reset command");

        repeat (2) tick();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule